// File: doc/BRIEF.md
# Memory Checksum/CRC Check Engine

The engine computes a 32-bit integrity value over a byte region of memory. Software supplies a start address, a length in bytes, an initial accumulator value and a command code, then pulses a trigger. The command code picks the arithmetic: a wrapping byte-sum checksum or a reflected CRC-32. While the run is under way the engine fetches aligned 32-bit words through a single-outstanding request/valid read port. It folds in only the bytes that lie inside the region, in little-endian lane order.

Progress is reported through a coded state value, a ready bit and a two-bit processing status. A sticky interrupt flag is raised twice per run: once when the engine leaves idle for a calculation state, and once when it returns to idle. When the run ends, the final value is left in a result register. A zero-length run still passes through the calculation state for one cycle, and its result is the initial value.

Top module: `memchk_engine`

## Requirements
- R1: After reset the state code reads 0x0001, ready is 1, processing status is 0, result is 0, the interrupt flag is 0 and no memory request is issued.
- R2: A trigger pulse while idle with command 0x04 moves the state code to 0x0004 in the next cycle, and command 0x05 moves it to 0x0005. In both cases ready drops to 0 and processing status becomes 1.
- R3: A trigger with any other command code, or any trigger while the state code is not 0x0001, is ignored: the state, result and fetch sequence are unchanged.
- R4: The interrupt flag is set in the cycle the engine enters a calculation state and again in the cycle it returns to idle. A one-cycle clear pulse resets it to 0, and a set event in the same cycle takes priority over the clear.
- R5: Under command 0x04 the result is the initial value plus every region byte, each zero-extended, taken modulo 2^32.
- R6: Under command 0x05 the result is the CRC-32 with reflected polynomial 0xEDB88320. It is seeded with the initial value, updated byte by byte starting at the lowest address, and has no final inversion. With seed 0xFFFFFFFF, the ASCII string "123456789" gives 0x340BC6D9.
- R7: Memory addresses issued always have bits [1:0] = 0. Byte lane k of a read word (bits 8k+7..8k) is the byte at word address + k. Lanes outside the region, at an unaligned start or end, are not used.
- R8: On completion the state code returns to 0x0001, ready returns to 1, processing status becomes 2 and the result register holds the final value. The result stays unchanged until the next run completes.
- R9: With a length of zero the state code shows the calculation state for exactly one cycle. The engine then returns to idle with no memory request, and the result equals the initial value.
- R10: At most one read is outstanding. A request lasts one cycle, the next request waits for the read-valid response, and a run issues exactly ceil((start mod 4 + length) / 4) requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_code | input | 8 | Command code (0x04 checksum, 0x05 CRC) |
| start_addr | input | 32 | First byte address of the region |
| byte_len | input | 32 | Region length in bytes |
| seed | input | 32 | Initial accumulator value |
| trig | input | 1 | One-cycle command trigger |
| irq_clr | input | 1 | One-cycle interrupt flag clear |
| state_code | output | 16 | Coded state: 0x0001 idle, 0x0004 checksum, 0x0005 CRC |
| ready | output | 1 | Command can be accepted |
| proc_status | output | 2 | 0 none yet, 1 running, 2 completed |
| irq_flag | output | 1 | Sticky interrupt flag |
| result | output | 32 | Final checksum or CRC |
| mem_req | output | 1 | Read request, one cycle |
| mem_addr | output | 32 | Word-aligned read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data, little-endian lanes |

## Verification
The assertions check the following on every cycle: the entry transitions for both command codes, rejection of unknown codes, the flag being set at both state boundaries, the completion status, aligned addresses and the single-request pulse. The arithmetic cannot be seen from a property. Only the bench's scenarios show that the checksum and CRC values are correct, that lane masking works for unaligned start and end, and that the request count per run matches the region. The same holds for zero-length runs, triggers arriving mid-run, and a known CRC vector. Those scenarios use several read latencies.

// File: rtl/memchk_pkg.sv
package memchk_pkg;
  localparam int ACC_W = 32;

  localparam logic [15:0] CODE_IDLE = 16'h0001;
  localparam logic [15:0] CODE_SUM  = 16'h0004;
  localparam logic [15:0] CODE_CRC  = 16'h0005;

  localparam logic [7:0] OP_SUM = 8'h04;
  localparam logic [7:0] OP_CRC = 8'h05;

  typedef enum logic [1:0] {
    PS_NONE = 2'd0,
    PS_BUSY = 2'd1,
    PS_DONE = 2'd2
  } proc_t;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_SUM  = 2'd1,
    ENG_CRC  = 2'd2
  } eng_t;

  // One byte of a right-shifting (reflected) CRC update.
  function automatic logic [ACC_W-1:0] crc_byte(input logic [ACC_W-1:0] c_in,
                                                input logic [7:0] b,
                                                input logic [ACC_W-1:0] poly_rev);
    logic [ACC_W-1:0] c;
    c = c_in ^ {{(ACC_W-8){1'b0}}, b};
    for (int k = 0; k < 8; k++) begin
      c = c[0] ? ((c >> 1) ^ poly_rev) : (c >> 1);
    end
    return c;
  endfunction
endpackage

// File: rtl/memchk_fetch.sv
module memchk_fetch #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic                     active,
  input  logic [ADDR_W-1:0]        base,
  input  logic [ADDR_W-1:0]        len,
  input  logic                     mem_rvalid,
  output logic                     mem_req,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [DATA_W/8-1:0]      lane_en,
  output logic                     beat,
  output logic                     empty
);
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  logic [ADDR_W-1:0] cur_q, cur_d;
  logic [ADDR_W-1:0] rem_q, rem_d;
  logic              pend_q, pend_d;
  logic [OFF_W-1:0]  off;
  logic [ADDR_W-1:0] room, take;

  always_comb begin
    off  = cur_q[OFF_W-1:0];
    room = ADDR_W'(LANES) - ADDR_W'(off);
    take = (rem_q < room) ? rem_q : room;
  end

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      assign lane_en[g] = (ADDR_W'(g) >= ADDR_W'(off)) &&
                          (ADDR_W'(g) < (ADDR_W'(off) + take));
    end
  endgenerate

  assign empty    = (rem_q == '0);
  assign mem_req  = active && !pend_q && !empty;
  assign beat     = pend_q && mem_rvalid;
  assign mem_addr = {cur_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  always_comb begin
    cur_d  = cur_q;
    rem_d  = rem_q;
    pend_d = pend_q;
    if (load) begin
      cur_d  = base;
      rem_d  = len;
      pend_d = 1'b0;
    end else if (beat) begin
      cur_d  = cur_q + take;
      rem_d  = rem_q - take;
      pend_d = 1'b0;
    end else if (mem_req) begin
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      rem_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cur_q  <= cur_d;
      rem_q  <= rem_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/memchk_accum.sv
module memchk_accum
  import memchk_pkg::*;
#(
  parameter int               DATA_W   = 32,
  parameter logic [ACC_W-1:0] POLY_REV = 32'hEDB88320
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [ACC_W-1:0]    init,
  input  logic                crc_mode,
  input  logic                update,
  input  logic [DATA_W/8-1:0] lane_en,
  input  logic [DATA_W-1:0]   word,
  output logic [ACC_W-1:0]    acc
);
  localparam int LANES = DATA_W / 8;

  logic [ACC_W-1:0] acc_q, acc_d, folded;

  // Lanes are folded lowest address first.
  always_comb begin
    folded = acc_q;
    for (int i = 0; i < LANES; i++) begin
      if (lane_en[i]) begin
        if (crc_mode) folded = crc_byte(folded, word[8*i +: 8], POLY_REV);
        else          folded = folded + {{(ACC_W-8){1'b0}}, word[8*i +: 8]};
      end
    end
  end

  always_comb begin
    acc_d = acc_q;
    if (load)        acc_d = init;
    else if (update) acc_d = folded;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc = acc_q;
endmodule

// File: rtl/memchk_ctrl.sv
module memchk_ctrl
  import memchk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic [7:0]       cmd_code,
  input  logic             irq_clr,
  input  logic             empty,
  input  logic [ACC_W-1:0] acc,
  output logic [15:0]      state_code,
  output logic             ready,
  output logic [1:0]       proc_status,
  output logic             irq_flag,
  output logic [ACC_W-1:0] result,
  output logic             load,
  output logic             active,
  output logic             crc_mode
);
  eng_t             st_q, st_d;
  logic             rdy_q, rdy_d;
  proc_t            ps_q, ps_d;
  logic             irq_q, irq_d;
  logic [ACC_W-1:0] res_q, res_d;
  logic             cmd_ok, accept, finish;

  assign cmd_ok = (cmd_code == OP_SUM) || (cmd_code == OP_CRC);
  assign accept = trig && (st_q == ENG_IDLE) && rdy_q && cmd_ok;
  assign finish = (st_q != ENG_IDLE) && empty;

  always_comb begin
    st_d  = st_q;
    rdy_d = rdy_q;
    ps_d  = ps_q;
    res_d = res_q;
    irq_d = irq_q;
    if (irq_clr) irq_d = 1'b0;
    if (accept) begin
      st_d  = (cmd_code == OP_CRC) ? ENG_CRC : ENG_SUM;
      rdy_d = 1'b0;
      ps_d  = PS_BUSY;
      irq_d = 1'b1;
    end else if (finish) begin
      st_d  = ENG_IDLE;
      rdy_d = 1'b1;
      ps_d  = PS_DONE;
      res_d = acc;
      irq_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ENG_IDLE;
      rdy_q <= 1'b1;
      ps_q  <= PS_NONE;
      irq_q <= 1'b0;
      res_q <= '0;
    end else begin
      st_q  <= st_d;
      rdy_q <= rdy_d;
      ps_q  <= ps_d;
      irq_q <= irq_d;
      res_q <= res_d;
    end
  end

  always_comb begin
    case (st_q)
      ENG_SUM: state_code = CODE_SUM;
      ENG_CRC: state_code = CODE_CRC;
      default: state_code = CODE_IDLE;
    endcase
  end

  assign ready       = rdy_q;
  assign proc_status = ps_q;
  assign irq_flag    = irq_q;
  assign result      = res_q;
  assign load        = accept;
  assign active      = (st_q != ENG_IDLE);
  assign crc_mode    = (st_q == ENG_CRC);
endmodule

// File: rtl/memchk_engine.sv
module memchk_engine
  import memchk_pkg::*;
#(
  parameter int               ADDR_W   = 32,
  parameter int               DATA_W   = 32,
  parameter logic [ACC_W-1:0] POLY_REV = 32'hEDB88320
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        cmd_code,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] byte_len,
  input  logic [ACC_W-1:0]  seed,
  input  logic              trig,
  input  logic              irq_clr,
  output logic [15:0]       state_code,
  output logic              ready,
  output logic [1:0]        proc_status,
  output logic              irq_flag,
  output logic [ACC_W-1:0]  result,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int LANES = DATA_W / 8;

  logic             load, active, crc_mode, beat, empty;
  logic [LANES-1:0] lane_en;
  logic [ACC_W-1:0] acc;

  memchk_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig       (trig),
    .cmd_code   (cmd_code),
    .irq_clr    (irq_clr),
    .empty      (empty),
    .acc        (acc),
    .state_code (state_code),
    .ready      (ready),
    .proc_status(proc_status),
    .irq_flag   (irq_flag),
    .result     (result),
    .load       (load),
    .active     (active),
    .crc_mode   (crc_mode)
  );

  memchk_fetch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .active    (active),
    .base      (start_addr),
    .len       (byte_len),
    .mem_rvalid(mem_rvalid),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .lane_en   (lane_en),
    .beat      (beat),
    .empty     (empty)
  );

  memchk_accum #(.DATA_W(DATA_W), .POLY_REV(POLY_REV)) u_accum (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .init    (seed),
    .crc_mode(crc_mode),
    .update  (beat),
    .lane_en (lane_en),
    .word    (mem_rdata),
    .acc     (acc)
  );
endmodule

// File: rtl/memchk_sva.sv
module memchk_sva
  import memchk_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        cmd_code,
  input logic              trig,
  input logic [15:0]       state_code,
  input logic              ready,
  input logic [1:0]        proc_status,
  input logic              irq_flag,
  input logic [31:0]       result,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr
);
  a_r2_enter_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == CODE_IDLE && ready && trig && cmd_code == OP_SUM)
      |=> (state_code == CODE_SUM && !ready && proc_status == 2'd1));

  a_r2_enter_crc: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == CODE_IDLE && ready && trig && cmd_code == OP_CRC)
      |=> (state_code == CODE_CRC && !ready && proc_status == 2'd1));

  a_r3_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == CODE_IDLE && trig && cmd_code != OP_SUM && cmd_code != OP_CRC)
      |=> (state_code == CODE_IDLE && $stable(result)));

  a_r4_flag_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code != CODE_IDLE && $past(state_code) == CODE_IDLE) |-> irq_flag);

  a_r4_flag_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == CODE_IDLE && $past(state_code) != CODE_IDLE) |-> irq_flag);

  a_r8_done_status: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == CODE_IDLE && $past(state_code) != CODE_IDLE)
      |-> (proc_status == 2'd2 && ready));

  a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_status == 2'd1) |-> !ready);

  a_r7_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  a_r10_no_idle_req: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == CODE_IDLE) |-> !mem_req);
endmodule

bind memchk_engine memchk_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_code   (cmd_code),
  .trig       (trig),
  .state_code (state_code),
  .ready      (ready),
  .proc_status(proc_status),
  .irq_flag   (irq_flag),
  .result     (result),
  .mem_req    (mem_req),
  .mem_addr   (mem_addr)
);

// File: tb/memchk_engine_test.sv
`timescale 1ns/1ps
module memchk_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cmd_code = 8'h00;
  logic [31:0] start_addr = '0, byte_len = '0, seed = '0;
  logic        trig = 1'b0, irq_clr = 1'b0;
  logic [15:0] state_code;
  logic        ready, irq_flag, mem_req;
  logic [1:0]  proc_status;
  logic [31:0] result, mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #10 clk = ~clk;

  memchk_engine uut (
    .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .start_addr(start_addr),
    .byte_len(byte_len), .seed(seed), .trig(trig), .irq_clr(irq_clr),
    .state_code(state_code), .ready(ready), .proc_status(proc_status),
    .irq_flag(irq_flag), .result(result), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  int vectors = 0;
  int errors  = 0;
  int reqs    = 0;
  int lat_sel = 0;
  bit done    = 1'b0;
  logic [31:0] model_result = '0;
  logic [7:0]  mem [256];

  // Memory responder: fixed latency chosen by lat_sel.
  int          lat_cnt = 0;
  logic [31:0] lat_addr = '0;
  always @(posedge clk) begin
    if (mem_req) begin
      lat_addr   <= mem_addr;
      lat_cnt    <= lat_sel + 1;
      mem_rvalid <= 1'b0;
    end else begin
      if (lat_cnt > 0) lat_cnt <= lat_cnt - 1;
      mem_rvalid <= (lat_cnt == 1);
      if (lat_cnt == 1)
        mem_rdata <= {mem[8'(lat_addr + 3)], mem[8'(lat_addr + 2)],
                      mem[8'(lat_addr + 1)], mem[8'(lat_addr)]};
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // Per-clock comparison against the behavioural model.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (mem_req) begin
        reqs++;
        chk("R7 aligned address", {30'b0, mem_addr[1:0]}, 32'h0);
      end
      if (state_code == 16'h0001) begin
        chk("R8 idle ready", {31'b0, ready}, 32'h1);
        chk("R8 held result", result, model_result);
      end else begin
        chk("R2 busy not ready", {31'b0, ready}, 32'h0);
      end
    end
  end

  function automatic logic [31:0] ref_value(input bit use_crc, input logic [31:0] a,
                                            input int n, input logic [31:0] init);
    logic [31:0] v;
    v = init;
    for (int k = 0; k < n; k++) begin
      logic [7:0] b;
      b = mem[8'(a + 32'(k))];
      if (use_crc) begin
        v = v ^ {24'h0, b};
        for (int j = 0; j < 8; j++) v = v[0] ? ((v >> 1) ^ 32'hEDB88320) : (v >> 1);
      end else begin
        v = v + {24'h0, b};
      end
    end
    return v;
  endfunction

  task automatic pulse_clear();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic run(input bit use_crc, input logic [31:0] a, input int n,
                     input logic [31:0] init, input int lat, input bit poke_busy,
                     input logic [31:0] fixed_exp, input bit use_fixed);
    logic [31:0] exp_v;
    logic [15:0] code;
    int          words, waited;
    code  = use_crc ? 16'h0005 : 16'h0004;
    exp_v = use_fixed ? fixed_exp : ref_value(use_crc, a, n, init);
    words = (n == 0) ? 0 : ((int'(a[1:0]) + n + 3) / 4);
    @(negedge clk);
    lat_sel = lat; cmd_code = use_crc ? 8'h05 : 8'h04;
    start_addr = a; byte_len = 32'(n); seed = init; trig = 1'b1; reqs = 0;
    @(negedge clk);
    trig = 1'b0;
    chk("R2 state after trigger", {16'h0, state_code}, {16'h0, code});
    chk("R2 status running", {30'b0, proc_status}, 32'h1);
    chk("R4 flag on entry", {31'b0, irq_flag}, 32'h1);
    model_result = exp_v;
    if (n == 0) begin
      @(negedge clk);
      chk("R9 zero length back to idle", {16'h0, state_code}, 32'h1);
      chk("R9 result is seed", result, init);
      chk("R9 flag on exit", {31'b0, irq_flag}, 32'h1);
      chk("R9 no request", 32'(reqs), 32'h0);
    end else begin
      if (poke_busy) begin
        cmd_code = use_crc ? 8'h04 : 8'h05; trig = 1'b1;
        @(negedge clk); trig = 1'b0;
        chk("R3 busy trigger ignored", {16'h0, state_code}, {16'h0, code});
      end
      pulse_clear();
      chk("R4 flag cleared", {31'b0, irq_flag}, 32'h0);
      waited = 0;
      while (state_code != 16'h0001 && waited < 500) begin
        @(negedge clk); waited++;
      end
      chk("R4 flag on exit", {31'b0, irq_flag}, 32'h1);
      chk("R8 status done", {30'b0, proc_status}, 32'h2);
      chk(use_crc ? "R6 crc result" : "R5 checksum result", result, exp_v);
      chk("R10 request count", 32'(reqs), 32'(words));
    end
    pulse_clear();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) & 255);
    for (int i = 0; i < 9; i++) mem[8'h80 + i] = 8'h31 + 8'(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset state", {16'h0, state_code}, 32'h1);
    chk("R1 reset ready", {31'b0, ready}, 32'h1);
    chk("R1 reset status", {30'b0, proc_status}, 32'h0);
    chk("R1 reset result", result, 32'h0);
    chk("R1 reset flag", {31'b0, irq_flag}, 32'h0);
    chk("R1 reset request", {31'b0, mem_req}, 32'h0);

    run(1'b0, 32'h00, 16, 32'h0000_0000, 0, 1'b0, 32'h0, 1'b0);
    run(1'b1, 32'h10, 12, 32'hFFFF_FFFF, 1, 1'b0, 32'h0, 1'b0);
    run(1'b0, 32'h23, 7,  32'h1234_5678, 2, 1'b0, 32'h0, 1'b0);   // R7 unaligned
    run(1'b1, 32'h31, 2,  32'h0000_0000, 0, 1'b0, 32'h0, 1'b0);   // R7 inside one word
    run(1'b1, 32'h80, 9,  32'hFFFF_FFFF, 1, 1'b0, 32'h340BC6D9, 1'b1); // R6 known vector
    run(1'b0, 32'hFFFF_FFF0, 5, 32'hFFFF_FFFE, 0, 1'b0, 32'h0, 1'b0); // R5 wrap
    run(1'b1, 32'h42, 0,  32'hCAFE_0001, 0, 1'b0, 32'h0, 1'b0);   // R9
    run(1'b0, 32'h05, 40, 32'h0000_0010, 2, 1'b1, 32'h0, 1'b0);   // R3 mid-run trigger

    // R3: unknown command in idle is ignored
    @(negedge clk);
    cmd_code = 8'h07; trig = 1'b1; reqs = 0;
    @(negedge clk);
    trig = 1'b0;
    chk("R3 unknown code state", {16'h0, state_code}, 32'h1);
    chk("R3 unknown code flag", {31'b0, irq_flag}, 32'h0);
    chk("R3 unknown code status", {30'b0, proc_status}, 32'h2);
    repeat (3) @(negedge clk);
    chk("R3 unknown code no fetch", 32'(reqs), 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule